// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog Timer

This block watches a free-running time base and expects software to service it at regular intervals. One of four time-base bits is chosen as the watchdog tick, and every 0-to-1 transition of that bit marks the end of one watchdog interval. When an interval ends and the watchdog is idle, the block raises a critical-class interrupt and sets its status bit. The interrupt handler is expected to clear the status.

If a second interval ends while the status is still set, the block stops waiting and requests a reset. Software chooses the kind of reset with a two-bit code. Once that code is non-zero it is locked until the block itself is reset, so a runaway program cannot disarm the watchdog. The time base and the reset controller that acts on the requests are outside this block.

Top module: `twostage_wdog`

## Requirements
- R1: `per_sel` picks the tick bit: 0, 1, 2 and 3 select time-base bits TAP0, TAP1, TAP2 and TAP3 (by default bits 16, 20, 24 and 28, which give intervals of 2^17, 2^21, 2^25 and 2^29 ticks). Only a rising edge of the selected bit counts, meaning 0 in one cycle and 1 in the next. Edges on bits that are not selected have no effect.
- R2: A tick edge while the status is clear sets `wd_stat` and `crit_irq` high in the following cycle.
- R3: A one-cycle `stat_clr` pulse while the interrupt is pending drops both `crit_irq` and `wd_stat` in the following cycle. A `stat_clr` pulse while idle changes nothing.
- R4: A tick edge while the interrupt is pending, with no clear in that cycle, starts a fire cycle in the following cycle. In the fire cycle `crit_irq` is low, `wd_stat` is high and the selected reset request is high. Every output is low in the cycle after that.
- R5: The reset-kind code selects the request output: 00 gives no request, 01 gives `rst_core_req`, 10 gives `rst_chip_req` and 11 gives `rst_sys_req`. At most one request output is high at any time.
- R6: After a non-zero kind code is written with `kind_wr`, later writes are ignored until `rst_n` is asserted.
- R7: After reset all outputs are low, the kind is 00 and the kind is unlocked. A tick bit that is already high when reset is released does not count until it has fallen and risen again.
- R8: If a clear and a tick edge arrive in the same cycle while the interrupt is pending, the clear takes precedence. The block returns to idle, and the next tick edge raises only the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| tbase | input | TB_W | Time-base value |
| per_sel | input | 2 | Selects which tick bit sets the interval |
| kind_wr | input | 1 | Write strobe for the reset-kind code |
| kind_din | input | 2 | Reset-kind code to be written |
| stat_clr | input | 1 | Write-one-to-clear strobe for the status |
| crit_irq | output | 1 | Critical interrupt, high while the first expiry is unserviced |
| wd_stat | output | 1 | Watchdog status bit |
| rst_core_req | output | 1 | One-cycle core reset request |
| rst_chip_req | output | 1 | One-cycle chip reset request |
| rst_sys_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with an 8-bit time base and taps at bits 1, 3, 5 and 7, and drives every tick edge directly. This turns intervals of up to 2^29 ticks into a few cycles each, so every period select, all four kind codes, the lock and the same-cycle clear-versus-tick race can be tested in one short run. Each time the kind code has to be written on an unlocked block, the bench first resets the block, which also covers the rule that only a reset removes the lock.

// File: rtl/twostage_wdog_pkg.sv
package twostage_wdog_pkg;
   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_FIRST = 2'd1,
      WS_FIRE  = 2'd2
   } wd_state_e;

   localparam int KIND_W = 2;
   localparam int NKINDS = 1 << KIND_W;
endpackage

// File: rtl/twostage_wdog_tap.sv
module twostage_wdog_tap #(
   parameter int TB_W = 32,
   parameter int TAP0 = 16,
   parameter int TAP1 = 20,
   parameter int TAP2 = 24,
   parameter int TAP3 = 28
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TB_W-1:0] tbase,
   input  logic [1:0]      per_sel,
   output logic            tap_rise
);
   localparam int NTAPS = 4;
   localparam int TAPS [NTAPS] = '{TAP0, TAP1, TAP2, TAP3};

   logic [NTAPS-1:0] cand;
   logic             sel_bit;
   logic             prev_q;
   logic             unused_tb;

   for (genvar g = 0; g < NTAPS; g++) begin : g_tap
      if (TAPS[g] < 0 || TAPS[g] >= TB_W) begin : g_bad
         $error("tap position outside the time base");
      end
      assign cand[g] = tbase[TAPS[g]];
   end

   assign unused_tb = ^tbase;
   assign sel_bit   = cand[per_sel];

   // Reset to 1 so that a bit already high at release is not taken as an edge.
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sel_bit;
   end

   assign tap_rise = sel_bit & ~prev_q;
endmodule

// File: rtl/twostage_wdog_fsm.sv
module twostage_wdog_fsm
   import twostage_wdog_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tap_rise,
   input  logic      stat_clr,
   output wd_state_e state_o
);
   wd_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WS_IDLE:  if (tap_rise) state_d = WS_FIRST;
         WS_FIRST: begin
            if (stat_clr)      state_d = WS_IDLE;
            else if (tap_rise) state_d = WS_FIRE;
         end
         WS_FIRE:  state_d = WS_IDLE;
         default:  state_d = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= WS_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/twostage_wdog_kind.sv
module twostage_wdog_kind
   import twostage_wdog_pkg::*;
#(
   parameter bit LOCK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kind_wr,
   input  logic [KIND_W-1:0] kind_din,
   input  logic              fire,
   output logic [NKINDS-1:0] req
);
   logic [KIND_W-1:0] kind_q;
   logic              lock_q;

   if (LOCK_EN) begin : g_lock
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            kind_q <= '0;
            lock_q <= 1'b0;
         end else if (kind_wr && !lock_q) begin
            kind_q <= kind_din;
            lock_q <= |kind_din;
         end
      end
   end else begin : g_free
      always_ff @(posedge clk) begin
         if (!rst_n)       kind_q <= '0;
         else if (kind_wr) kind_q <= kind_din;
      end
      assign lock_q = 1'b0;
   end

   assign req[0] = 1'b0;
   for (genvar g = 1; g < NKINDS; g++) begin : g_dec
      assign req[g] = fire && (kind_q == KIND_W'(g));
   end

   AST_KIND_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(kind_q)); // R6
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
   import twostage_wdog_pkg::*;
#(
   parameter int TB_W    = 32,
   parameter int TAP0    = 16,
   parameter int TAP1    = 20,
   parameter int TAP2    = 24,
   parameter int TAP3    = 28,
   parameter bit LOCK_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TB_W-1:0] tbase,
   input  logic [1:0]      per_sel,
   input  logic            kind_wr,
   input  logic [1:0]      kind_din,
   input  logic            stat_clr,
   output logic            crit_irq,
   output logic            wd_stat,
   output logic            rst_core_req,
   output logic            rst_chip_req,
   output logic            rst_sys_req
);
   logic              tap_rise;
   wd_state_e         state;
   logic [NKINDS-1:0] req;
   logic              any_req;

   twostage_wdog_tap #(.TB_W(TB_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)) tap_i (
      .clk(clk), .rst_n(rst_n), .tbase(tbase), .per_sel(per_sel), .tap_rise(tap_rise));

   twostage_wdog_fsm fsm_i (
      .clk(clk), .rst_n(rst_n), .tap_rise(tap_rise), .stat_clr(stat_clr), .state_o(state));

   twostage_wdog_kind #(.LOCK_EN(LOCK_EN)) kind_i (
      .clk(clk), .rst_n(rst_n), .kind_wr(kind_wr), .kind_din(kind_din),
      .fire(state == WS_FIRE), .req(req));

   assign crit_irq     = (state == WS_FIRST);
   assign wd_stat      = (state != WS_IDLE);
   assign rst_core_req = req[1];
   assign rst_chip_req = req[2];
   assign rst_sys_req  = req[3];
   assign any_req      = rst_core_req | rst_chip_req | rst_sys_req;

   AST_ARM_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_stat && tap_rise) |=> (crit_irq && wd_stat)); // R2
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (crit_irq && stat_clr) |=> (!crit_irq && !wd_stat)); // R3
   AST_SECOND_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (crit_irq && tap_rise && !stat_clr) |=> (!crit_irq && wd_stat)); // R4
   AST_FIRE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_stat && !crit_irq) |=> !wd_stat); // R4
   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |=> !any_req); // R4
   AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_core_req, rst_chip_req, rst_sys_req})); // R5
endmodule

// File: tb/twostage_wdog_tb.sv
module twostage_wdog_tb_top;
   localparam int CLK_P = 10;
   localparam int TB_W  = 8;

   typedef struct {
      logic [3:0] code;
      string      tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [TB_W-1:0] tbase = '0;
   logic [1:0]      per_sel = 2'd0;
   logic            kind_wr = 1'b0;
   logic [1:0]      kind_din = 2'd0;
   logic            stat_clr = 1'b0;
   logic            crit_irq, wd_stat, rst_core_req, rst_chip_req, rst_sys_req;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;
   exp_t q[$];
   logic irq_q = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   twostage_wdog #(.TB_W(TB_W), .TAP0(1), .TAP1(3), .TAP2(5), .TAP3(7)) dut_i (
      .clk(clk), .rst_n(rst_n), .tbase(tbase), .per_sel(per_sel),
      .kind_wr(kind_wr), .kind_din(kind_din), .stat_clr(stat_clr),
      .crit_irq(crit_irq), .wd_stat(wd_stat), .rst_core_req(rst_core_req),
      .rst_chip_req(rst_chip_req), .rst_sys_req(rst_sys_req));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int tap_of(input logic [1:0] s);
      return 2 * s + 1;
   endfunction

   // Event code: bit0 interrupt rise, bit1 core, bit2 chip, bit3 system request.
   task automatic push(input logic [3:0] code, input string tag);
      exp_t e;
      e.code = code;
      e.tag  = tag;
      q.push_back(e);
   endtask

   // Monitor: outputs change only at posedge, sampled at negedge.
   always @(negedge clk) begin
      logic [3:0] ev;
      if (!rst_n) irq_q = 1'b0;
      else begin
         ev = {rst_sys_req, rst_chip_req, rst_core_req, crit_irq & ~irq_q};
         if (ev != 4'd0) begin
            if (q.size() == 0) chk(1'b0, "unexpected event", int'(ev), 0);
            else begin
               exp_t e;
               e = q.pop_front();
               chk(ev == e.code, e.tag, int'(ev), int'(e.code));
            end
         end
         irq_q = crit_irq;
      end
   end

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk) rst_n = 1'b1;
   endtask

   // Tick edge on a chosen bit; returns at the negedge after the edge is taken.
   task automatic edge_on(input int b);
      @(negedge clk) tbase = '0;
      @(negedge clk) tbase = TB_W'(1) << b;
      @(negedge clk);
   endtask

   task automatic expire();
      edge_on(tap_of(per_sel));
   endtask

   task automatic clear();
      @(negedge clk) stat_clr = 1'b1;
      @(negedge clk) stat_clr = 1'b0;
   endtask

   task automatic write_kind(input logic [1:0] k);
      @(negedge clk) begin kind_wr = 1'b1; kind_din = k; end
      @(negedge clk) kind_wr = 1'b0;
   endtask

   task automatic two_expiries(input logic [3:0] code, input string tag);
      push(4'b0001, tag);
      expire();
      push(code, tag);
      expire();
      chk(wd_stat && !crit_irq, {tag, " fire cycle status"}, int'({wd_stat, crit_irq}), 2);
      @(negedge clk);
      chk({rst_sys_req, rst_chip_req, rst_core_req, wd_stat} == 4'd0,
          {tag, " after fire"}, int'({rst_sys_req, rst_chip_req, rst_core_req, wd_stat}), 0);
   endtask

   initial begin
      tbase = '1;
      @(negedge clk);
      @(negedge clk) rst_n = 1'b1;
      chk({crit_irq, wd_stat, rst_core_req, rst_chip_req, rst_sys_req} == 5'd0, "R7 reset state",
          int'({crit_irq, wd_stat, rst_core_req, rst_chip_req, rst_sys_req}), 0);
      repeat (2) @(negedge clk);
      chk(!wd_stat, "R7 bit high at release not an edge", int'(wd_stat), 0);

      clear();
      @(negedge clk);
      chk(!wd_stat && !crit_irq, "R3 clear while idle", int'({wd_stat, crit_irq}), 0);

      push(4'b0001, "R2 first expiry interrupt");
      expire();
      chk(wd_stat && crit_irq, "R2 status and irq", int'({wd_stat, crit_irq}), 3);
      clear();
      chk(!wd_stat && !crit_irq, "R3 clear drops irq", int'({wd_stat, crit_irq}), 0);

      per_sel = 2'd2;
      edge_on(1);
      edge_on(3);
      chk(!wd_stat, "R1 unselected bits ignored", int'(wd_stat), 0);
      push(4'b0001, "R1 selected tap bit 5");
      expire();
      push(4'b0000, "R5 kind none");
      q.pop_back();
      expire();
      chk(wd_stat && !crit_irq && !(rst_core_req | rst_chip_req | rst_sys_req), "R5 kind none no request",
          int'({wd_stat, crit_irq, rst_core_req, rst_chip_req, rst_sys_req}), 16);
      @(negedge clk);
      chk(!wd_stat, "R4 back to idle", int'(wd_stat), 0);

      per_sel = 2'd3;
      push(4'b0001, "R8 first irq");
      expire();
      @(negedge clk) tbase = '0;
      @(negedge clk) begin tbase = TB_W'(1) << 7; stat_clr = 1'b1; end
      @(negedge clk) stat_clr = 1'b0;
      chk(!wd_stat && !crit_irq, "R8 clear beats edge", int'({wd_stat, crit_irq}), 0);
      push(4'b0001, "R8 next edge only interrupt");
      expire();
      chk(crit_irq, "R8 interrupt again", int'(crit_irq), 1);
      clear();

      do_reset();
      per_sel = 2'd0;
      write_kind(2'd2);
      write_kind(2'd0);
      two_expiries(4'b0100, "R6 chip locked against 00");

      do_reset();
      write_kind(2'd3);
      write_kind(2'd1);
      two_expiries(4'b1000, "R6 sys locked against 01");

      do_reset();
      per_sel = 2'd1;
      write_kind(2'd1);
      two_expiries(4'b0010, "R5 core request");

      repeat (2) @(negedge clk);
      chk(q.size() == 0, "R4 all expected events seen", q.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule